// File: doc/BRIEF.md
# Triggered Eight-Channel Readout Sequencer

This block is the digital control of an eight-channel detector front-end. A discriminator pulse on any channel sets that channel's bit in a hit register. As soon as any bit is set, the block pulls a shared open-drain service-request line low. While that line is low, whether the chip or the host holds it, the hit register is frozen and later pulses are dropped.

The host keeps the line low for the whole readout and paces the transfer with a slow readout clock. The block does nothing until the first rising edge of that clock. It then shifts out the 8-bit hit mask. Next it walks the triggered channels in ascending order. For each one it sets the analog multiplexer, starts a conversion and waits for the converter's done strobe. It flags end-of-conversion and shifts the 10-bit result out on the data pin. The pin changes on falling edges of the readout clock.

A host reset pulse clears the hit register, releases the line and arms capture again. The readout clock is oversampled by the system clock through a synchronizer.

Top module: `srq_readout_top`

## Requirements
- R1: After rst_ni is asserted, srq_oe_o, data_o, adc_start_o and eoc_o are all 0.
- R2: A high pulse on trig_i[k] while the line is high sets hit bit k, and srq_oe_o then goes to 1. srq_o is always 0, so the line is driven low only.
- R3: While srq_line_ni is low, whether the chip or the host pulls it, pulses on trig_i leave the hit register unchanged.
- R4: adc_start_o stays 0 until the first rising edge of rd_clk_i is seen while the line is low.
- R5: After that edge, the next 8 falling edges of rd_clk_i place the hit mask on data_o, bit 7 first and bit 0 last.
- R6: Each triggered channel then yields one 10-bit word on data_o, bit 9 first, one bit per falling edge. Words come in ascending channel order. adc_start_o is a one-cycle pulse with mux_sel_o equal to the channel number.
- R7: A channel whose hit bit is 0 is skipped: it gets no conversion start and no data word. The number of starts equals the number of set bits.
- R8: eoc_o pulses for one cycle, in the cycle after adc_done_i is seen, once per conversion.
- R9: After the last word, the next falling edge of rd_clk_i drives data_o to 0. It stays 0 until the host reset.
- R10: A one-cycle host_rst_i pulse clears the hit register and drops srq_oe_o. It returns the sequencer to idle, even in the middle of a readout, and capture then works again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 8 | Discriminator pulses, one per channel |
| srq_line_ni | input | 1 | Sensed level of the shared service-request line, low = active |
| srq_oe_o | output | 1 | Pull-down enable for the service-request pad |
| srq_o | output | 1 | Drive value for the pad, constant 0 |
| rd_clk_i | input | 1 | Readout clock from the host, asynchronous |
| host_rst_i | input | 1 | Host reset pulse, synchronous |
| mux_sel_o | output | 3 | Analog multiplexer channel select |
| adc_start_o | output | 1 | Conversion start pulse |
| adc_done_i | input | 1 | Conversion done strobe |
| adc_data_i | input | 10 | Conversion result, valid with adc_done_i |
| eoc_o | output | 1 | End-of-conversion flag |
| data_o | output | 1 | Serial readout data |

## Verification
The bench sends trigger pulses after capture has frozen, once with the chip holding the line and once with the host holding it. A design that kept capturing would put an extra bit in the shifted mask. The masks used have sparse, full and edge-channel patterns. A priority search that skipped the wrong way, or failed at channel 0 or channel 7, would start the wrong number of conversions or shift out words in the wrong order. The bench also checks that the pin falls to 0 after the last word. It then aborts a readout midway and expects a clean restart with a fresh mask, which catches a sequencer that resumes stale state or leaves the line held.

// File: rtl/srq_readout_pkg.sv
package srq_readout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MASK,
    ST_FIND,
    ST_CONV,
    ST_WORD,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/rd_edge_sync.sv
module rd_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_clk_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], rd_clk_i};
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  sync_q[SYNC_STAGES];
endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           line_act_i,
  input  logic [NCH-1:0] trig_i,
  output logic [NCH-1:0] mask_o,
  output logic           req_o
);
  logic [NCH-1:0] hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hit_q <= '0;
    else if (clr_i)       hit_q <= '0;
    else if (!line_act_i) hit_q <= hit_q | trig_i;
  end

  assign mask_o = hit_q;
  assign req_o  = |hit_q;

  AST_FREEZE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_act_i && !clr_i) |=> $stable(hit_q)); // R3
  AST_RESET_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !req_o); // R10
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import srq_readout_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned ADC_W = 10,
  localparam int unsigned SEL_W = $clog2(NCH),
  localparam int unsigned PTR_W = $clog2(NCH + 1),
  localparam int unsigned SH_W  = (NCH > ADC_W) ? NCH : ADC_W,
  localparam int unsigned CNT_W = $clog2(SH_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             line_act_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [NCH-1:0]   mask_i,
  input  logic             adc_done_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic [SEL_W-1:0] mux_sel_o,
  output logic             adc_start_o,
  output logic             eoc_o,
  output logic             data_o
);
  seq_state_e       state_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] ptr_q;
  logic [SEL_W-1:0] sel_q;
  logic             start_q, eoc_q, data_q;

  // lowest set hit bit at or above the scan pointer
  logic             found;
  logic [SEL_W-1:0] nxt_ch;
  always_comb begin
    found  = 1'b0;
    nxt_ch = '0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && mask_i[i] && (PTR_W'(i) >= ptr_q)) begin
        found  = 1'b1;
        nxt_ch = SEL_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      sel_q   <= '0;
      start_q <= 1'b0;
      eoc_q   <= 1'b0;
      data_q  <= 1'b0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      start_q <= 1'b0;
      eoc_q   <= 1'b0;
      data_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      eoc_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (line_act_i && rise_i) begin
          sh_q    <= SH_W'(mask_i) << (SH_W - NCH);
          cnt_q   <= '0;
          ptr_q   <= '0;
          state_q <= ST_MASK;
        end
        ST_MASK: if (fall_i) begin
          data_q <= sh_q[SH_W-1];
          sh_q   <= sh_q << 1;
          if (cnt_q == CNT_W'(NCH - 1)) state_q <= ST_FIND;
          else                          cnt_q   <= cnt_q + 1'b1;
        end
        ST_FIND: begin
          if (found) begin
            sel_q   <= nxt_ch;
            start_q <= 1'b1;
            ptr_q   <= PTR_W'(nxt_ch) + 1'b1;
            state_q <= ST_CONV;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_CONV: if (adc_done_i) begin
          sh_q    <= SH_W'(adc_data_i) << (SH_W - ADC_W);
          cnt_q   <= '0;
          eoc_q   <= 1'b1;
          state_q <= ST_WORD;
        end
        ST_WORD: if (fall_i) begin
          data_q <= sh_q[SH_W-1];
          sh_q   <= sh_q << 1;
          if (cnt_q == CNT_W'(ADC_W - 1)) state_q <= ST_FIND;
          else                            cnt_q   <= cnt_q + 1'b1;
        end
        ST_DONE: if (fall_i) data_q <= 1'b0;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mux_sel_o   = sel_q;
  assign adc_start_o = start_q;
  assign eoc_o       = eoc_q;
  assign data_o      = data_q;

  AST_START_ON_TRIGGERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> mask_i[mux_sel_o]); // R7
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o); // R6
  AST_EOC_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> $past(adc_done_i)); // R8
  AST_DONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && fall_i) |=> !data_o); // R9
endmodule

// File: rtl/srq_readout_top.sv
module srq_readout_top #(
  parameter int unsigned NCH         = 8,
  parameter int unsigned ADC_W       = 10,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   trig_i,
  input  logic             srq_line_ni,
  output logic             srq_oe_o,
  output logic             srq_o,
  input  logic             rd_clk_i,
  input  logic             host_rst_i,
  output logic [SEL_W-1:0] mux_sel_o,
  output logic             adc_start_o,
  input  logic             adc_done_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic             eoc_o,
  output logic             data_o
);
  logic           line_act, rise, fall, req;
  logic [NCH-1:0] mask;

  assign line_act = ~srq_line_ni;

  trig_capture #(.NCH(NCH)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (host_rst_i),
    .line_act_i (line_act),
    .trig_i     (trig_i),
    .mask_o     (mask),
    .req_o      (req)
  );

  rd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_clk_i (rd_clk_i),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  readout_seq #(.NCH(NCH), .ADC_W(ADC_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (host_rst_i),
    .line_act_i  (line_act),
    .rise_i      (rise),
    .fall_i      (fall),
    .mask_i      (mask),
    .adc_done_i  (adc_done_i),
    .adc_data_i  (adc_data_i),
    .mux_sel_o   (mux_sel_o),
    .adc_start_o (adc_start_o),
    .eoc_o       (eoc_o),
    .data_o      (data_o)
  );

  assign srq_oe_o = req;
  assign srq_o    = 1'b0; // open drain: pull low only

  AST_REQ_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_act && |trig_i && !host_rst_i) |=> srq_oe_o); // R2
endmodule

// File: tb/srq_readout_top_test.sv
module srq_readout_top_test;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] trig = '0;
  logic       host_pull = 1'b0;
  logic       rd_clk = 1'b0;
  logic       host_rst = 1'b0;
  logic       srq_line, srq_oe, srq_drv, adc_start, eoc, data;
  logic [2:0] mux_sel;
  logic       adc_done = 1'b0;
  logic [9:0] adc_data = '0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // open-drain line with pull-up
  assign srq_line = ~((srq_oe && !srq_drv) || host_pull);

  srq_readout_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig), .srq_line_ni(srq_line),
    .srq_oe_o(srq_oe), .srq_o(srq_drv), .rd_clk_i(rd_clk), .host_rst_i(host_rst),
    .mux_sel_o(mux_sel), .adc_start_o(adc_start), .adc_done_i(adc_done),
    .adc_data_i(adc_data), .eoc_o(eoc), .data_o(data)
  );

  function automatic logic [9:0] adc_val(input int ch);
    return 10'((ch * 77 + 300) % 1024);
  endfunction

  // converter model and monitors
  int conv_cnt = 0;
  int conv_ch = 0;
  int n_starts = 0;
  int n_eoc = 0;
  int start_log [8];
  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (eoc) n_eoc <= n_eoc + 1;
    if (adc_start) begin
      if (n_starts < 8) start_log[n_starts] <= int'(mux_sel);
      n_starts <= n_starts + 1;
      conv_cnt <= 3;
      conv_ch  <= int'(mux_sel);
    end else if (conv_cnt > 0) begin
      conv_cnt <= conv_cnt - 1;
      if (conv_cnt == 1) begin
        adc_done <= 1'b1;
        adc_data <= adc_val(conv_ch);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    n_starts = 0;
    n_eoc = 0;
  endtask

  task automatic pulse_trig(input logic [7:0] m);
    @(negedge clk) trig = m;
    @(negedge clk) trig = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_host_reset();
    @(negedge clk) host_rst = 1'b1;
    @(negedge clk) host_rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_bit(output logic b);
    @(negedge clk) rd_clk = 1'b0;
    repeat (H) @(negedge clk);
    b = data;
    rd_clk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic rd_start();
    @(negedge clk) rd_clk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  // full readout with expected mask
  task automatic readout(input logic [7:0] exp_mask);
    logic       b;
    logic [7:0] m;
    logic [9:0] w;
    int         k;
    clear_logs();
    host_pull = 1'b1;
    repeat (20) @(negedge clk);
    chk("R4 no start before rd clock", n_starts, 0);
    rd_start();
    m = '0;
    for (int i = 0; i < 8; i++) begin rd_bit(b); m = {m[6:0], b}; end
    chk("R5 mask shifted msb first", m, exp_mask);
    k = 0;
    for (int ch = 0; ch < 8; ch++) begin
      if (exp_mask[ch]) begin
        w = '0;
        for (int i = 0; i < 10; i++) begin rd_bit(b); w = {w[8:0], b}; end
        chk($sformatf("R6 word ch%0d", ch), w, adc_val(ch));
        if (k < 8) chk($sformatf("R6 mux order #%0d", k), start_log[k], ch);
        k++;
      end
    end
    chk("R7 starts equal set bits", n_starts, k);
    chk("R8 eoc per conversion", n_eoc, k);
    rd_bit(b);
    chk("R9 data low after last word", b, 0);
    rd_bit(b);
    chk("R9 data stays low", b, 0);
    host_pull = 1'b0;
    @(negedge clk) rd_clk = 1'b0;
    do_host_reset();
    chk("R10 line released", srq_oe, 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 srq_oe", srq_oe, 0);
    chk("R1 data", data, 0);
    chk("R1 start", adc_start, 0);
    chk("R1 eoc", eoc, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_chip_freeze();
    pulse_trig(8'h05);
    chk("R2 request after trigger", srq_oe, 1);
    chk("R2 drive value low", srq_drv, 0);
    pulse_trig(8'h80); // dropped: line already low
    readout(8'h05);
  endtask

  task automatic t_host_freeze();
    @(negedge clk) host_pull = 1'b1;
    pulse_trig(8'h10);
    chk("R3 no capture while host holds line", srq_oe, 0);
    @(negedge clk) host_pull = 1'b0;
    pulse_trig(8'h81);
    chk("R2 request after edge channels", srq_oe, 1);
    readout(8'h81);
  endtask

  task automatic t_all();
    pulse_trig(8'hFF);
    readout(8'hFF);
  endtask

  task automatic t_abort();
    logic b;
    logic [7:0] m;
    pulse_trig(8'h42);
    clear_logs();
    host_pull = 1'b1;
    rd_start();
    m = '0;
    for (int i = 0; i < 8; i++) begin rd_bit(b); m = {m[6:0], b}; end
    chk("R5 mask before abort", m, 8'h42);
    rd_bit(b);
    host_pull = 1'b0;
    @(negedge clk) rd_clk = 1'b0;
    do_host_reset();
    repeat (10) @(negedge clk);
    chk("R10 abort releases line", srq_oe, 0);
    chk("R10 abort clears data", data, 0);
    pulse_trig(8'h08);
    chk("R10 capture re-armed", srq_oe, 1);
    readout(8'h08);
  endtask

  initial begin
    t_reset();
    t_chip_freeze();
    t_host_freeze();
    t_all();
    t_abort();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule